// File: doc/BRIEF.md
# L1 Cache Bus Command Formatter

This block sits between an L1 cache controller and its single-initiator bus port. The controller hands over one request at a time on a valid/ready port. A request carries a kind, a word address, a word count, a write-buffer slot index, and up to eight lanes of write data with their byte enables. The block turns each request into a command packet and sends it one flit per accepted transfer. Every flit carries a command code, a byte address, a packet length in bytes, a transaction identifier, byte enables, write data and an end-of-packet mark.

The kinds are:
- uncached and cached reads, each as one flit;
- write-buffer bursts of up to half a cache line;
- linked loads and store-conditionals, each as one flit;
- cleanup notices for evicted data or instruction lines, each as one flit.

The transaction identifier tells the kinds apart. For a read it holds the read class. For a write its top bit is set and the remaining bits hold the write-buffer slot. For a cleanup it holds the cache side. A write burst that is empty, too long, or would leave its aligned half line is rejected with a one-cycle error pulse, and nothing goes out on the bus. Request kind codes 6 and 7 are rejected the same way.

Top module: `l1_cmd_formatter`

## Requirements
- R1: During and straight after reset, `cmd_valid` and `req_err` are 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The first flit of an accepted packet shows `cmd_valid` in the next cycle. `req_ready` stays low from then until the edge that transfers the last flit.
- R3: Read kinds are sent as one flit: uncached read is kind 0 and cached read is kind 1. The flit has command code 2'b01, EOP 1, byte enables all ones and write data 0. An uncached read addresses the requested word (address = word address × 4) with length 4. A cached read addresses the start of the 16-word line holding the word (low 6 byte-address bits cleared) with length 64.
- R4: The identifier of a read is {0, 0, cached, instruction}. The instruction bit is `req_inst`, so the values are 0 uncached data, 1 uncached instruction, 2 cached data and 3 cached instruction.
- R5: A legal write (kind 2) with N words sends N flits with command code 2'b10 and length N×4. Flit i addresses word `req_addr`+i and carries data lane i (`req_wdata[i*32 +: 32]`) and byte-enable lane i (`req_be[i*4 +: 4]`). A byte-enable lane of all zeros is sent as given. EOP is 1 only on the last flit.
- R6: Every write flit carries the identifier {1, `req_slot`}.
- R7: A write is rejected when N is 0, N is greater than 8, or (word address mod 8) + N is greater than 8. `req_err` is then 1 for exactly the cycle after acceptance, and no flit is sent.
- R8: A linked load (kind 3) is one flit with command code 2'b11, byte enables all ones and data 0. A store-conditional (kind 4) is one flit with command code 2'b00 carrying data lane 0 and byte-enable lane 0. Both address the requested word, use length 4 and identifier 0.
- R9: A cleanup (kind 5) is one flit with command code 2'b10, length 4, byte enables all ones and data 0. It is addressed to the start of the line holding the word. Its identifier is 0 for a data-cache line and 1 for an instruction-cache line, taken from `req_inst`.
- R10: Kinds 6 and 7 are rejected exactly as in R7.
- R11: While `cmd_valid` is high and `cmd_ready` is low, every command field holds its value into the next cycle, and `cmd_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 3 | 0 uncached read, 1 cached read, 2 write, 3 linked load, 4 store-conditional, 5 cleanup |
| req_inst | input | 1 | Instruction-side request (reads, cleanup) |
| req_addr | input | WADDR_W (30) | Word address |
| req_nwords | input | NW_W (4) | Write word count |
| req_slot | input | SLOT_W (3) | Write-buffer slot index |
| req_wdata | input | HALF_WORDS*DATA_W (256) | Write data lanes, lane i at i*DATA_W |
| req_be | input | HALF_WORDS*BE_W (32) | Byte-enable lanes, lane i at i*BE_W |
| req_err | output | 1 | Rejected-request pulse |
| cmd_valid | output | 1 | Command flit valid |
| cmd_ready | input | 1 | Downstream accepts flit |
| cmd_code | output | 2 | Command code |
| cmd_addr | output | ADDR_W (32) | Byte address |
| cmd_plen | output | PLEN_W (7) | Packet length in bytes |
| cmd_trdid | output | TRDID_W (4) | Transaction identifier |
| cmd_be | output | BE_W (4) | Flit byte enables |
| cmd_wdata | output | DATA_W (32) | Flit write data |
| cmd_eop | output | 1 | Last flit of packet |

## Verification
Both results of a request are due one cycle after the edge that takes it: either the first flit or the error pulse. The bench therefore drives a request at a falling edge and checks the outcome at the next falling edge. From there it checks one flit each cycle and moves to the next expected flit only after an edge at which `cmd_ready` was high. Because of this, a stalled flit is compared again unchanged. `req_ready` is checked at the falling edge that follows the last transfer, and `req_err` is checked again one cycle after its pulse to confirm it has dropped.

// File: rtl/l1cf_pkg.sv
package l1cf_pkg;

   typedef enum logic [2:0] {
      K_RD_UNC    = 3'd0,
      K_RD_CACHED = 3'd1,
      K_WRITE     = 3'd2,
      K_LINK_LD   = 3'd3,
      K_STORE_CND = 3'd4,
      K_CLEANUP   = 3'd5
   } req_kind_e;

   localparam logic [1:0] CODE_SC    = 2'b00;
   localparam logic [1:0] CODE_READ  = 2'b01;
   localparam logic [1:0] CODE_WRITE = 2'b10;
   localparam logic [1:0] CODE_LL    = 2'b11;

endpackage

// File: rtl/l1cf_decode.sv
module l1cf_decode
   import l1cf_pkg::*;
#(
   parameter int WADDR_W    = 30,
   parameter int BE_W       = 4,
   parameter int LINE_WORDS = 16,
   parameter int SLOT_W     = 3,
   parameter int NW_W       = 4,
   parameter int TRDID_W    = 4,
   parameter int PLEN_W     = 7
) (
   input  logic [2:0]         kind,
   input  logic               inst,
   input  logic [WADDR_W-1:0] addr,
   input  logic [NW_W-1:0]    nwords,
   input  logic [SLOT_W-1:0]  slot,
   output logic [1:0]         code,
   output logic [TRDID_W-1:0] trdid,
   output logic [PLEN_W-1:0]  plen,
   output logic [WADDR_W-1:0] base,
   output logic [NW_W-1:0]    nflits,
   output logic               use_idx,
   output logic               use_lane0,
   output logic               bad
);
   localparam int HALF     = LINE_WORDS / 2;
   localparam int LINE_LSB = $clog2(LINE_WORDS);
   localparam int HALF_LSB = $clog2(HALF);

   logic [WADDR_W-1:0] line_base;
   logic [NW_W:0]      span;

   assign line_base = {addr[WADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
   assign span      = (NW_W+1)'(addr[HALF_LSB-1:0]) + {1'b0, nwords};

   always_comb begin
      code      = CODE_READ;
      trdid     = '0;
      plen      = PLEN_W'(BE_W);
      base      = addr;
      nflits    = NW_W'(1);
      use_idx   = 1'b0;
      use_lane0 = 1'b0;
      bad       = 1'b0;
      case (req_kind_e'(kind))
         K_RD_UNC: begin
            trdid = TRDID_W'({1'b0, inst});
         end
         K_RD_CACHED: begin
            trdid = TRDID_W'({1'b1, inst});
            plen  = PLEN_W'(LINE_WORDS * BE_W);
            base  = line_base;
         end
         K_WRITE: begin
            code    = CODE_WRITE;
            trdid   = {1'b1, slot};
            plen    = PLEN_W'(nwords) * PLEN_W'(BE_W);
            nflits  = nwords;
            use_idx = 1'b1;
            bad     = (nwords == '0) || (nwords > NW_W'(HALF)) ||
                      (span > (NW_W+1)'(HALF));
         end
         K_LINK_LD: begin
            code = CODE_LL;
         end
         K_STORE_CND: begin
            code      = CODE_SC;
            use_lane0 = 1'b1;
         end
         K_CLEANUP: begin
            code  = CODE_WRITE;
            trdid = TRDID_W'(inst);
            base  = line_base;
         end
         default: begin
            bad = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/l1cf_flit_seq.sv
module l1cf_flit_seq #(
   parameter int NW_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            reject,
   input  logic [NW_W-1:0] nflits,
   input  logic            fire,
   output logic            busy,
   output logic [NW_W-1:0] idx,
   output logic            last,
   output logic            err
);
   assign last = (idx == nflits - NW_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         err  <= 1'b0;
      end else begin
         err <= accept && reject;
         if (accept && !reject) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (fire) begin
            if (last) begin
               busy <= 1'b0;
            end else begin
               idx <= idx + NW_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/l1cf_lane_sel.sv
module l1cf_lane_sel #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4,
   parameter int LANES  = 8,
   parameter int IDX_W  = 4
) (
   input  logic [LANES*DATA_W-1:0] lanes_data,
   input  logic [LANES*BE_W-1:0]   lanes_be,
   input  logic [IDX_W-1:0]        idx,
   input  logic                    use_idx,
   input  logic                    use_lane0,
   output logic [DATA_W-1:0]       wdata,
   output logic [BE_W-1:0]         be
);
   localparam int SEL_W = $clog2(LANES);

   logic [DATA_W-1:0] ld [LANES];
   logic [BE_W-1:0]   lb [LANES];
   logic              in_range;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign ld[g] = lanes_data[g*DATA_W +: DATA_W];
      assign lb[g] = lanes_be[g*BE_W +: BE_W];
   end

   assign in_range = (idx < IDX_W'(LANES));

   always_comb begin
      wdata = '0;
      be    = '1;
      if (use_idx) begin
         if (in_range) begin
            wdata = ld[idx[SEL_W-1:0]];
            be    = lb[idx[SEL_W-1:0]];
         end else begin
            be = '0;
         end
      end else if (use_lane0) begin
         wdata = ld[0];
         be    = lb[0];
      end
   end

endmodule

// File: rtl/l1_cmd_formatter.sv
module l1_cmd_formatter #(
   parameter  int WADDR_W    = 30,
   parameter  int DATA_W     = 32,
   parameter  int LINE_WORDS = 16,
   parameter  int SLOT_W     = 3,
   localparam int BE_W       = DATA_W / 8,
   localparam int BYTE_LSB   = $clog2(BE_W),
   localparam int HALF_WORDS = LINE_WORDS / 2,
   localparam int NW_W       = $clog2(HALF_WORDS) + 1,
   localparam int TRDID_W    = SLOT_W + 1,
   localparam int PLEN_W     = $clog2(LINE_WORDS * BE_W) + 1,
   localparam int ADDR_W     = WADDR_W + BYTE_LSB
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [2:0]                   req_kind,
   input  logic                         req_inst,
   input  logic [WADDR_W-1:0]           req_addr,
   input  logic [NW_W-1:0]              req_nwords,
   input  logic [SLOT_W-1:0]            req_slot,
   input  logic [HALF_WORDS*DATA_W-1:0] req_wdata,
   input  logic [HALF_WORDS*BE_W-1:0]   req_be,
   output logic                         req_err,
   output logic                         cmd_valid,
   input  logic                         cmd_ready,
   output logic [1:0]                   cmd_code,
   output logic [ADDR_W-1:0]            cmd_addr,
   output logic [PLEN_W-1:0]            cmd_plen,
   output logic [TRDID_W-1:0]           cmd_trdid,
   output logic [BE_W-1:0]              cmd_be,
   output logic [DATA_W-1:0]            cmd_wdata,
   output logic                         cmd_eop
);
   if (DATA_W < 16 || (DATA_W % 8) != 0 || (BE_W & (BE_W - 1)) != 0) begin : g_bad_data
      $error("l1_cmd_formatter: DATA_W must be a power-of-two byte count of at least 2 bytes");
   end
   if (LINE_WORDS < 4 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("l1_cmd_formatter: LINE_WORDS must be a power of two, at least 4");
   end
   if (SLOT_W < 1) begin : g_bad_slot
      $error("l1_cmd_formatter: SLOT_W must be at least 1");
   end
   if (WADDR_W <= $clog2(LINE_WORDS)) begin : g_bad_addr
      $error("l1_cmd_formatter: WADDR_W too small for one line");
   end

   logic [1:0]         d_code;
   logic [TRDID_W-1:0] d_trdid;
   logic [PLEN_W-1:0]  d_plen;
   logic [WADDR_W-1:0] d_base;
   logic [NW_W-1:0]    d_nflits;
   logic               d_use_idx, d_use_lane0, d_bad;

   logic [1:0]                   h_code;
   logic [TRDID_W-1:0]           h_trdid;
   logic [PLEN_W-1:0]            h_plen;
   logic [WADDR_W-1:0]           h_base;
   logic [NW_W-1:0]              h_nflits;
   logic                         h_use_idx, h_use_lane0;
   logic [HALF_WORDS*DATA_W-1:0] h_wdata;
   logic [HALF_WORDS*BE_W-1:0]   h_be;

   logic            busy, last, accept, fire;
   logic [NW_W-1:0] idx;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign fire      = cmd_valid && cmd_ready;

   l1cf_decode #(
      .WADDR_W(WADDR_W), .BE_W(BE_W), .LINE_WORDS(LINE_WORDS), .SLOT_W(SLOT_W),
      .NW_W(NW_W), .TRDID_W(TRDID_W), .PLEN_W(PLEN_W)
   ) u_decode (
      .kind(req_kind), .inst(req_inst), .addr(req_addr), .nwords(req_nwords),
      .slot(req_slot), .code(d_code), .trdid(d_trdid), .plen(d_plen),
      .base(d_base), .nflits(d_nflits), .use_idx(d_use_idx),
      .use_lane0(d_use_lane0), .bad(d_bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_code      <= '0;
         h_trdid     <= '0;
         h_plen      <= '0;
         h_base      <= '0;
         h_nflits    <= NW_W'(1);
         h_use_idx   <= 1'b0;
         h_use_lane0 <= 1'b0;
         h_wdata     <= '0;
         h_be        <= '0;
      end else if (accept && !d_bad) begin
         h_code      <= d_code;
         h_trdid     <= d_trdid;
         h_plen      <= d_plen;
         h_base      <= d_base;
         h_nflits    <= d_nflits;
         h_use_idx   <= d_use_idx;
         h_use_lane0 <= d_use_lane0;
         h_wdata     <= req_wdata;
         h_be        <= req_be;
      end
   end

   l1cf_flit_seq #(.NW_W(NW_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .reject(d_bad),
      .nflits(h_nflits), .fire(fire), .busy(busy), .idx(idx), .last(last),
      .err(req_err)
   );

   l1cf_lane_sel #(
      .DATA_W(DATA_W), .BE_W(BE_W), .LANES(HALF_WORDS), .IDX_W(NW_W)
   ) u_lane (
      .lanes_data(h_wdata), .lanes_be(h_be), .idx(idx), .use_idx(h_use_idx),
      .use_lane0(h_use_lane0), .wdata(cmd_wdata), .be(cmd_be)
   );

   assign cmd_valid = busy;
   assign cmd_code  = h_code;
   assign cmd_trdid = h_trdid;
   assign cmd_plen  = h_plen;
   assign cmd_addr  = {h_base + WADDR_W'(idx), {BYTE_LSB{1'b0}}};
   assign cmd_eop   = last;

endmodule

// File: rtl/l1cf_chk.sv
module l1cf_chk
   import l1cf_pkg::*;
#(
   parameter  int WADDR_W    = 30,
   parameter  int DATA_W     = 32,
   parameter  int LINE_WORDS = 16,
   parameter  int SLOT_W     = 3,
   localparam int BE_W       = DATA_W / 8,
   localparam int BYTE_LSB   = $clog2(BE_W),
   localparam int TRDID_W    = SLOT_W + 1,
   localparam int PLEN_W     = $clog2(LINE_WORDS * BE_W) + 1,
   localparam int ADDR_W     = WADDR_W + BYTE_LSB
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               req_err,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic [1:0]         cmd_code,
   input logic [ADDR_W-1:0]  cmd_addr,
   input logic [PLEN_W-1:0]  cmd_plen,
   input logic [TRDID_W-1:0] cmd_trdid,
   input logic [BE_W-1:0]    cmd_be,
   input logic [DATA_W-1:0]  cmd_wdata,
   input logic               cmd_eop
);
   // R2
   busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !req_ready);

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) &&
         $stable(cmd_addr) && $stable(cmd_plen) && $stable(cmd_trdid) &&
         $stable(cmd_be) && $stable(cmd_wdata) && $stable(cmd_eop)));

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && !cmd_eop) |=>
         (cmd_valid && cmd_addr == $past(cmd_addr) + ADDR_W'(BE_W)));

   // R6
   burst_trdid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_eop) |-> (cmd_code == CODE_WRITE && cmd_trdid[TRDID_W-1]));

   // R3
   read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CODE_READ) |->
         (cmd_eop && (cmd_plen == PLEN_W'(BE_W) || cmd_plen == PLEN_W'(LINE_WORDS * BE_W))));

   // R8
   atomic_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_code == CODE_LL || cmd_code == CODE_SC)) |->
         (cmd_eop && cmd_trdid == '0));

   // R7
   err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> ($past(req_valid && req_ready) && !cmd_valid));

endmodule

bind l1_cmd_formatter l1cf_chk #(
   .WADDR_W(WADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .SLOT_W(SLOT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_err(req_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_plen(cmd_plen),
   .cmd_trdid(cmd_trdid), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
   .cmd_eop(cmd_eop)
);

// File: tb/l1_cmd_formatter_bench.sv
`timescale 1ns/1ps
module l1_cmd_formatter_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [2:0]   req_kind = '0;
   logic         req_inst = 1'b0;
   logic [29:0]  req_addr = '0;
   logic [3:0]   req_nwords = '0;
   logic [2:0]   req_slot = '0;
   logic [255:0] req_wdata = '0;
   logic [31:0]  req_be = '0;
   logic         req_err;
   logic         cmd_valid;
   logic         cmd_ready = 1'b0;
   logic [1:0]   cmd_code;
   logic [31:0]  cmd_addr;
   logic [6:0]   cmd_plen;
   logic [3:0]   cmd_trdid;
   logic [3:0]   cmd_be;
   logic [31:0]  cmd_wdata;
   logic         cmd_eop;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   l1_cmd_formatter u_l1_cmd_formatter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_inst(req_inst), .req_addr(req_addr),
      .req_nwords(req_nwords), .req_slot(req_slot), .req_wdata(req_wdata),
      .req_be(req_be), .req_err(req_err), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .cmd_plen(cmd_plen), .cmd_trdid(cmd_trdid), .cmd_be(cmd_be),
      .cmd_wdata(cmd_wdata), .cmd_eop(cmd_eop)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL R2 watchdog: got hang expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [127:0] got,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic bit exp_bad(input logic [2:0] k, input logic [29:0] a,
                                  input logic [3:0] nw);
      if (k > 3'd5) return 1'b1;
      if (k != 3'd2) return 1'b0;
      return (nw == 0) || (nw > 8) || ((int'(a[2:0]) + int'(nw)) > 8);
   endfunction

   function automatic int exp_count(input logic [2:0] k, input logic [3:0] nw);
      return (k == 3'd2) ? int'(nw) : 1;
   endfunction

   // fields other than TRDID: {code, addr, plen, be, wdata, eop}
   function automatic logic [77:0] exp_fields(input logic [2:0] k, input logic [29:0] a,
         input logic [3:0] nw, input logic [255:0] wd, input logic [31:0] be, input int i);
      logic [1:0]  c;
      logic [31:0] ad;
      logic [6:0]  pl;
      logic [3:0]  b;
      logic [31:0] d;
      c = 2'b01; ad = {a, 2'b00}; pl = 7'd4; b = 4'hF; d = '0;
      case (k)
         3'd1: begin ad = {a[29:4], 6'b0}; pl = 7'd64; end
         3'd2: begin c = 2'b10; ad = {a + 30'(i), 2'b00}; pl = 7'(nw) * 7'd4;
                     b = be[i*4 +: 4]; d = wd[i*32 +: 32]; end
         3'd3: c = 2'b11;
         3'd4: begin c = 2'b00; b = be[3:0]; d = wd[31:0]; end
         3'd5: begin c = 2'b10; ad = {a[29:4], 6'b0}; end
         default: ;
      endcase
      return {c, ad, pl, b, d, (i == exp_count(k, nw) - 1)};
   endfunction

   function automatic logic [3:0] exp_trdid(input logic [2:0] k, input bit in,
                                            input logic [2:0] sl);
      case (k)
         3'd0: return {3'b000, in};
         3'd1: return {3'b001, in};
         3'd2: return {1'b1, sl};
         3'd5: return {3'b000, in};
         default: return 4'd0;
      endcase
   endfunction

   function automatic string field_tag(input logic [2:0] k);
      case (k)
         3'd0, 3'd1: return "R3";
         3'd2: return "R5";
         3'd3, 3'd4: return "R8";
         default: return "R9";
      endcase
   endfunction

   function automatic string id_tag(input logic [2:0] k);
      case (k)
         3'd0, 3'd1: return "R4";
         3'd2: return "R6";
         3'd3, 3'd4: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic run_req(input logic [2:0] k, input bit in, input logic [29:0] a,
         input logic [3:0] nw, input logic [2:0] sl, input logic [255:0] wd,
         input logic [31:0] be, input int stall_pct);
      int n;
      int i;
      bit rdy;
      bit stalled;
      n = exp_count(k, nw);
      @(negedge clk);
      check(req_ready == 1'b1, "R2 ready when idle", 128'(req_ready), 128'(1));
      req_valid = 1'b1; req_kind = k; req_inst = in; req_addr = a;
      req_nwords = nw; req_slot = sl; req_wdata = wd; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      if (exp_bad(k, a, nw)) begin
         check(req_err == 1'b1 && cmd_valid == 1'b0, (k > 3'd5) ? "R10" : "R7",
               128'({req_err, cmd_valid}), 128'(2'b10));
         @(negedge clk);
         check(req_err == 1'b0 && cmd_valid == 1'b0, (k > 3'd5) ? "R10 pulse" : "R7 pulse",
               128'({req_err, cmd_valid}), 128'(2'b00));
      end else begin
         check(cmd_valid == 1'b1 && req_err == 1'b0, "R2 first flit",
               128'({cmd_valid, req_err}), 128'(2'b10));
         i = 0;
         stalled = 1'b0;
         while (i < n) begin
            rdy = ($urandom % 100) >= stall_pct;
            cmd_ready = rdy;
            if (cmd_valid !== 1'b1 || req_ready !== 1'b0) begin
               check(1'b0, "R2 flit present", 128'({cmd_valid, req_ready}), 128'(2'b10));
               break;
            end
            check({cmd_code, cmd_addr, cmd_plen, cmd_be, cmd_wdata, cmd_eop} ==
                  exp_fields(k, a, nw, wd, be, i), stalled ? "R11" : field_tag(k),
                  128'({cmd_code, cmd_addr, cmd_plen, cmd_be, cmd_wdata, cmd_eop}),
                  128'(exp_fields(k, a, nw, wd, be, i)));
            check(cmd_trdid == exp_trdid(k, in, sl), id_tag(k),
                  128'(cmd_trdid), 128'(exp_trdid(k, in, sl)));
            @(negedge clk);
            stalled = !rdy;
            if (rdy) i++;
         end
         cmd_ready = 1'b0;
         check(cmd_valid == 1'b0 && req_ready == 1'b1, "R2 release",
               128'({cmd_valid, req_ready}), 128'(2'b01));
      end
   endtask

   function automatic logic [255:0] rnd_data();
      logic [255:0] v;
      for (int j = 0; j < 8; j++) v[j*32 +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      void'($urandom(32'h5eed_1c0d));
      repeat (3) @(negedge clk);
      // R1
      check(cmd_valid == 1'b0 && req_err == 1'b0 && req_ready == 1'b1, "R1 in reset",
            128'({cmd_valid, req_err, req_ready}), 128'(3'b001));
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_valid == 1'b0 && req_err == 1'b0 && req_ready == 1'b1, "R1 after reset",
            128'({cmd_valid, req_err, req_ready}), 128'(3'b001));

      // directed corner cases
      run_req(3'd0, 1'b0, 30'h0123_4567, 4'd0, 3'd0, rnd_data(), 32'hFFFF_FFFF, 0);
      run_req(3'd0, 1'b1, 30'h0000_0005, 4'd3, 3'd2, rnd_data(), 32'h0, 0);
      run_req(3'd1, 1'b0, 30'h0000_00FF, 4'd1, 3'd0, rnd_data(), 32'h0, 0);
      run_req(3'd1, 1'b1, 30'h3FFF_FFF7, 4'd0, 3'd0, rnd_data(), 32'h0, 50);
      run_req(3'd2, 1'b0, 30'h0000_0100, 4'd8, 3'd5, rnd_data(), 32'h1234_F0A5, 0);
      run_req(3'd2, 1'b0, 30'h0000_0107, 4'd1, 3'd7, rnd_data(), 32'h0000_0003, 60);
      run_req(3'd2, 1'b0, 30'h0000_0208, 4'd4, 3'd0, rnd_data(), 32'h0000_0F00, 40);
      run_req(3'd2, 1'b0, 30'h0000_0306, 4'd3, 3'd1, rnd_data(), 32'hFFFF_FFFF, 0);
      run_req(3'd2, 1'b0, 30'h0000_0300, 4'd9, 3'd1, rnd_data(), 32'hFFFF_FFFF, 0);
      run_req(3'd2, 1'b0, 30'h0000_0300, 4'd0, 3'd1, rnd_data(), 32'hFFFF_FFFF, 0);
      run_req(3'd3, 1'b1, 30'h0000_0ABC, 4'd2, 3'd3, rnd_data(), 32'h0000_0005, 0);
      run_req(3'd4, 1'b0, 30'h0000_0ABD, 4'd0, 3'd3, rnd_data(), 32'h0000_0009, 50);
      run_req(3'd5, 1'b0, 30'h0000_1235, 4'd0, 3'd0, rnd_data(), 32'h0, 0);
      run_req(3'd5, 1'b1, 30'h0000_123F, 4'd0, 3'd0, rnd_data(), 32'h0, 0);
      run_req(3'd6, 1'b0, 30'h0000_0010, 4'd1, 3'd0, rnd_data(), 32'h0, 0);
      run_req(3'd7, 1'b1, 30'h0000_0010, 4'd2, 3'd0, rnd_data(), 32'h0, 0);

      // constrained random
      for (int t = 0; t < 300; t++) begin
         logic [2:0]  k;
         logic [29:0] a;
         logic [3:0]  nw;
         int          r;
         r = $urandom % 16;
         if (r < 3) k = 3'd0;
         else if (r < 6) k = 3'd1;
         else if (r < 11) k = 3'd2;
         else if (r == 11) k = 3'd3;
         else if (r == 12) k = 3'd4;
         else if (r == 13) k = 3'd5;
         else if (r == 14) k = 3'd5;
         else k = 3'(6 + ($urandom % 2));
         a = 30'($urandom);
         if (($urandom % 4) != 0) nw = 4'(1 + ($urandom % (8 - int'(a[2:0]))));
         else nw = 4'($urandom % 11);
         run_req(k, 1'($urandom), a, nw, 3'($urandom), rnd_data(), $urandom,
                 int'($urandom % 60));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule